// File: doc/BRIEF.md
# Exception Level State Bank

This block keeps the architectural state that a processor with four privilege levels (0 to 3) needs when it takes and leaves exceptions. It holds the live status word, a saved status word and a saved resume address for each of levels 1, 2 and 3, and four stack-pointer registers, one per level. On an accepted exception entry it files the status word from just before the entry and the resume address in the bank of the target level. It then moves the live status to that level with the dedicated pointer selected. On an exception return it copies the current level's saved status back into the live status word.

The live status word carries the current level in bits [3:2] and the stack-pointer select bit in bit 0; the other bits are opaque flags that the block only stores. The active stack pointer is the shared level-0 pointer at level 0, or whenever the select bit is 0. Otherwise it is the pointer that belongs to the current level. The pipeline drives one entry, return, status update or pointer update per cycle and reads the active pointer and the pending resume address combinationally.

Top module: `el_state_bank`

## Requirements
- R1: After reset the live status equals the reset value 0x000D (level 3, select bit 1). All four stack pointers and all saved status words and resume addresses are zero, and both error flags are low.
- R2: An accepted entry to level T writes the entry address into T's resume-address register and the live status from before the entry into T's saved-status register, visible from the next cycle.
- R3: An entry is accepted when its target is 1 to 3 and not below the current level. From the next cycle the live status shows level T in bits [3:2] and 1 in bit 0, with all other bits unchanged.
- R4: An entry whose target is 0 or below the current level raises `entry_err` for exactly the next cycle and changes no state.
- R5: A return request at level 1 to 3 (with no entry in the same cycle) loads the live status from that level's saved status word in the next cycle.
- R6: `resume_addr` always shows the resume-address register of the current level, and shows zero at level 0.
- R7: A return request at level 0 (with no entry in the same cycle) raises `eret_err` for exactly the next cycle and changes no state.
- R8: `sp_active` is stack pointer 0 at level 0 or when bit 0 is 0, and otherwise the stack pointer numbered by the current level.
- R9: A stack-pointer write stores `sp_wr_data` in the pointer active in that cycle, before any level change made in the same cycle, and leaves the other three pointers untouched.
- R10: In one cycle an entry request (accepted or not) takes precedence over a return request, and both take precedence over a live-status write; the losing requests are ignored.
- R11: A live-status write with no entry or return request replaces the live status word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_valid | input | 1 | Exception entry request |
| entry_level | input | 2 | Target level of the entry |
| entry_addr | input | AW | Address to resume at after the exception |
| eret_valid | input | 1 | Exception return request |
| status_wr_en | input | 1 | Live status update from the pipeline |
| status_wr_data | input | SW | New live status word |
| sp_wr_en | input | 1 | Write to the active stack pointer |
| sp_wr_data | input | AW | Stack pointer write value |
| status_q | output | SW | Live status word |
| cur_level | output | 2 | Current level (status bits [3:2]) |
| sp_active | output | AW | Active stack pointer |
| resume_addr | output | AW | Saved resume address of the current level |
| entry_err | output | 1 | Rejected entry, one cycle after the request |
| eret_err | output | 1 | Return at level 0, one cycle after the request |

## Verification
A wrong bank entry stays hidden until the level that owns it becomes current. A bad resume address then shows on `resume_addr` in the cycle the level is entered, and a bad saved status shows on `status_q` one cycle after the return. A stack pointer stored in the wrong slot shows on `sp_active` only once the level and select bit that pick that slot are live. For this reason the bench sweeps every starting level, select bit and target. It then runs a long mixed stream against a model, so that every slot is read back after it was written.

// File: rtl/elsb_pkg.sv
package elsb_pkg;
  typedef logic [1:0] lvl_t;

  localparam int NUM_LVL = 4;
  localparam int LVL_LSB = 2;
  localparam int SEL_POS = 0;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ENTER = 2'd1,
    OP_RET   = 2'd2,
    OP_WRITE = 2'd3
  } op_e;
endpackage

// File: rtl/elsb_save_bank.sv
module elsb_save_bank
  import elsb_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_en,
  input  lvl_t          save_lvl,
  input  logic [AW-1:0] save_addr,
  input  logic [SW-1:0] save_status,
  input  lvl_t          rd_lvl,
  output logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_status
);
  logic [AW-1:0] addr_q [NUM_LVL];
  logic [SW-1:0] stat_q [NUM_LVL];

  // level 0 owns no save slot
  assign addr_q[0] = '0;
  assign stat_q[0] = '0;

  for (genvar g = 1; g < NUM_LVL; g++) begin : g_slot
    logic slot_en;
    assign slot_en = save_en && (save_lvl == lvl_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        stat_q[g] <= '0;
      end else if (slot_en) begin
        addr_q[g] <= save_addr;
        stat_q[g] <= save_status;
      end
    end
  end

  assign rd_addr   = addr_q[rd_lvl];
  assign rd_status = stat_q[rd_lvl];

  p_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> (addr_q[$past(save_lvl)] == $past(save_addr)) &&
                (stat_q[$past(save_lvl)] == $past(save_status)));

  p_rd_l0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lvl == 2'd0) |-> (rd_addr == '0));
endmodule

// File: rtl/elsb_sp_bank.sv
module elsb_sp_bank
  import elsb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lvl_t          cur_level,
  input  logic          sel_h,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] active
);
  logic [AW-1:0] sp_q [NUM_LVL];
  lvl_t          act_idx;

  always_comb begin
    if (sel_h && (cur_level != 2'd0)) act_idx = cur_level;
    else                              act_idx = 2'd0;
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_sp
    logic sp_en;
    assign sp_en = wr_en && (act_idx == lvl_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp_q[g] <= '0;
      else if (sp_en) sp_q[g] <= wr_data;
    end
  end

  assign active = sp_q[act_idx];

  p_sp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sp_q[$past(act_idx)] == $past(wr_data));

  p_l0_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd0 || !sel_h) |-> active == sp_q[0]);
endmodule

// File: rtl/elsb_ctrl.sv
module elsb_ctrl
  import elsb_pkg::*;
#(
  parameter int            SW         = 16,
  parameter logic [SW-1:0] RST_STATUS = 16'h000D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_valid,
  input  lvl_t          entry_level,
  input  logic          eret_valid,
  input  logic          status_wr_en,
  input  logic [SW-1:0] status_wr_data,
  input  logic [SW-1:0] saved_status,
  output logic [SW-1:0] status_q,
  output lvl_t          cur_level,
  output logic          sel_h,
  output logic          save_en,
  output logic          entry_err,
  output logic          eret_err
);
  op_e           op;
  logic          entry_ok;
  logic          ret_ok;
  logic [SW-1:0] status_d;
  logic          status_en;
  logic          entry_err_d;
  logic          eret_err_d;

  assign cur_level = status_q[LVL_LSB +: 2];
  assign sel_h     = status_q[SEL_POS];

  always_comb begin
    if (entry_valid)       op = OP_ENTER;
    else if (eret_valid)   op = OP_RET;
    else if (status_wr_en) op = OP_WRITE;
    else                   op = OP_IDLE;
  end

  assign entry_ok = (entry_level != 2'd0) && (entry_level >= cur_level);
  assign ret_ok   = (cur_level != 2'd0);

  always_comb begin
    status_d    = status_q;
    status_en   = 1'b0;
    save_en     = 1'b0;
    entry_err_d = 1'b0;
    eret_err_d  = 1'b0;
    unique case (op)
      OP_ENTER: begin
        if (entry_ok) begin
          save_en                  = 1'b1;
          status_en                = 1'b1;
          status_d[LVL_LSB +: 2]   = entry_level;
          status_d[SEL_POS]        = 1'b1;
        end else begin
          entry_err_d = 1'b1;
        end
      end
      OP_RET: begin
        if (ret_ok) begin
          status_en = 1'b1;
          status_d  = saved_status;
        end else begin
          eret_err_d = 1'b1;
        end
      end
      OP_WRITE: begin
        status_en = 1'b1;
        status_d  = status_wr_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= RST_STATUS;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_err <= 1'b0;
      eret_err  <= 1'b0;
    end else begin
      entry_err <= entry_err_d;
      eret_err  <= eret_err_d;
    end
  end

  p_entry_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && (entry_level == 2'd0 || entry_level < cur_level))
      |=> entry_err && $stable(status_q));

  p_entry_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_level != 2'd0 && entry_level >= cur_level)
      |=> (cur_level == $past(entry_level)) && sel_h);

  p_eret_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_valid && eret_valid && cur_level != 2'd0)
      |=> status_q == $past(saved_status));

  p_eret_l0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_valid && eret_valid && cur_level == 2'd0)
      |=> eret_err && $stable(status_q));

  p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_err, eret_err}));
endmodule

// File: rtl/el_state_bank.sv
module el_state_bank
  import elsb_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            SW         = 16,
  parameter logic [SW-1:0] RST_STATUS = 16'h000D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_valid,
  input  logic [1:0]    entry_level,
  input  logic [AW-1:0] entry_addr,
  input  logic          eret_valid,
  input  logic          status_wr_en,
  input  logic [SW-1:0] status_wr_data,
  input  logic          sp_wr_en,
  input  logic [AW-1:0] sp_wr_data,
  output logic [SW-1:0] status_q,
  output logic [1:0]    cur_level,
  output logic [AW-1:0] sp_active,
  output logic [AW-1:0] resume_addr,
  output logic          entry_err,
  output logic          eret_err
);
  logic          sel_h;
  logic          save_en;
  logic [SW-1:0] saved_status;
  lvl_t          lvl;

  assign cur_level = lvl;

  elsb_ctrl #(.SW(SW), .RST_STATUS(RST_STATUS)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .entry_valid    (entry_valid),
    .entry_level    (entry_level),
    .eret_valid     (eret_valid),
    .status_wr_en   (status_wr_en),
    .status_wr_data (status_wr_data),
    .saved_status   (saved_status),
    .status_q       (status_q),
    .cur_level      (lvl),
    .sel_h          (sel_h),
    .save_en        (save_en),
    .entry_err      (entry_err),
    .eret_err       (eret_err)
  );

  elsb_save_bank #(.AW(AW), .SW(SW)) u_save (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_en     (save_en),
    .save_lvl    (entry_level),
    .save_addr   (entry_addr),
    .save_status (status_q),
    .rd_lvl      (lvl),
    .rd_addr     (resume_addr),
    .rd_status   (saved_status)
  );

  elsb_sp_bank #(.AW(AW)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_level (lvl),
    .sel_h     (sel_h),
    .wr_en     (sp_wr_en),
    .wr_data   (sp_wr_data),
    .active    (sp_active)
  );
endmodule

// File: tb/el_state_bank_test.sv
module el_state_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          entry_valid = 1'b0;
  logic [1:0]    entry_level = '0;
  logic [AW-1:0] entry_addr = '0;
  logic          eret_valid = 1'b0;
  logic          status_wr_en = 1'b0;
  logic [SW-1:0] status_wr_data = '0;
  logic          sp_wr_en = 1'b0;
  logic [AW-1:0] sp_wr_data = '0;
  logic [SW-1:0] status_q;
  logic [1:0]    cur_level;
  logic [AW-1:0] sp_active;
  logic [AW-1:0] resume_addr;
  logic          entry_err;
  logic          eret_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the architectural state
  logic [SW-1:0] m_st;
  logic [AW-1:0] m_sp   [4];
  logic [AW-1:0] m_addr [4];
  logic [SW-1:0] m_sav  [4];
  logic          m_eerr, m_rerr;
  logic [31:0]   rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  el_state_bank #(.AW(AW), .SW(SW)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] m_idx();
    if (m_st[0] && m_st[3:2] != 2'd0) return m_st[3:2];
    return 2'd0;
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, 64'(status_q), 64'(m_st));
    chk("R8", 64'(sp_active), 64'(m_sp[m_idx()]));
    chk("R6", 64'(resume_addr), (m_st[3:2] == 2'd0) ? 64'd0 : 64'(m_addr[m_st[3:2]]));
    chk("R4", 64'(entry_err), 64'(m_eerr));
    chk("R7", 64'(eret_err), 64'(m_rerr));
  endtask

  // one cycle: inputs applied after a falling edge, sampled at the next falling edge
  task automatic step(input logic ev, input logic [1:0] el, input logic [AW-1:0] ea,
                      input logic rv, input logic sw, input logic [SW-1:0] swd,
                      input logic pw, input logic [AW-1:0] pwd);
    logic [1:0] cur;
    string tag;
    entry_valid = ev; entry_level = el; entry_addr = ea;
    eret_valid = rv; status_wr_en = sw; status_wr_data = swd;
    sp_wr_en = pw; sp_wr_data = pwd;
    cur = m_st[3:2];
    tag = "R11";
    if (pw) m_sp[m_idx()] = pwd;   // R9: pre-change selection
    m_eerr = 0; m_rerr = 0;
    if (ev) begin
      tag = "R3";
      if (el == 2'd0 || el < cur) m_eerr = 1;
      else begin
        m_sav[el] = m_st; m_addr[el] = ea;
        m_st[3:2] = el; m_st[0] = 1'b1;
      end
    end else if (rv) begin
      tag = "R5";
      if (cur == 2'd0) m_rerr = 1;
      else m_st = m_sav[cur];
    end else if (sw) m_st = swd;
    if (ev && (rv || sw) || rv && sw) tag = "R10";
    @(posedge clk);
    @(negedge clk);
    entry_valid = 0; eret_valid = 0; status_wr_en = 0; sp_wr_en = 0;
    compare_all(tag);
    if (pw) chk("R9", 64'(sp_active), 64'(m_sp[m_idx()]));
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_st = 16'h000D;
    for (int i = 0; i < 4; i++) begin m_sp[i] = '0; m_addr[i] = '0; m_sav[i] = '0; end
    m_eerr = 0; m_rerr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    chk("R1", 64'(cur_level), 64'd3);

    // give each pointer a distinct value: R9 / R8
    for (int l = 0; l < 4; l++) begin
      step(0, 0, 0, 0, 1, 16'(l << 2) | 16'h0001, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 32'hA000_0000 + 32'(l));
    end

    // sweep starting level, select bit and target: R2 R3 R4 R5 R7
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 4; t++) begin
          logic [SW-1:0] w;
          w = 16'h5A00 | 16'(c << 2) | 16'(s);
          step(0, 0, 0, 0, 1, w, 0, 0);
          chk("R8", 64'(sp_active), 64'(m_sp[m_idx()]));
          step(1, 2'(t), 32'hC0DE_0000 + 32'(c*16 + s*4 + t), 0, 0, 0, 0, 0);
          if (t != 0 && t >= c) chk("R2", 64'(resume_addr), 64'(32'hC0DE_0000 + 32'(c*16 + s*4 + t)));
          step(0, 0, 0, 1, 0, 0, 0, 0);
          if (t != 0 && t >= c) chk("R5", 64'(status_q), 64'(w));
        end

    // same-cycle collisions: R10
    step(0, 0, 0, 0, 1, 16'h0005, 0, 0);
    step(1, 2'd2, 32'h1111_2222, 1, 1, 16'hFFFF, 1, 32'h3333_4444);
    step(0, 0, 0, 1, 1, 16'h0000, 0, 0);
    step(1, 2'd0, 0, 1, 0, 0, 0, 0);

    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      rng = nxt(rng);
      step(rng[0] & rng[1], rng[3:2], {rng[31:16], rng[15:0] ^ 16'(i)},
           rng[4] & rng[5], rng[6] & rng[7] & rng[8],
           {rng[27:16] & 12'h0F3, rng[11:10] , rng[9] , rng[12]} ,
           rng[13], rng ^ 32'(i));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule